// File: doc/BRIEF.md
# Contiguous Hardware Thread Range Allocator

This block tracks which of the T hardware thread contexts of one core are in use and, on request, finds a run of consecutive free thread IDs for a block of a given padded size. Candidate runs are tried one per cycle, starting at ID 0 and moving up in steps equal to the requested size. The first run that is entirely free is reported by its start ID. When the occupy flag is set, that run is marked busy and its start is stored against a block-context slot number. When the occupy flag is clear, the request is only a probe and changes nothing.

A later release needs only the slot number and the run length. The block looks up the stored start, frees the run and forgets the slot. Misuse is reported on a one-cycle error flag: claiming a slot that is already held, or releasing a slot that holds nothing. In both cases nothing is changed.

The controller has three states. `ST_IDLE` accepts requests. `ST_SCAN` tests one candidate per cycle. `ST_DONE` presents the result for one cycle. The transitions are:
- `IDLE->SCAN` on an accepted, well-formed allocation.
- `IDLE->DONE` on an allocation that is rejected at once.
- `SCAN->SCAN` when a candidate is busy and another remains.
- `SCAN->DONE` when a candidate is free or the candidates are used up.
- `DONE->IDLE` always.

Releases are served in `ST_IDLE` without leaving it.

Top module: `thr_range_alloc`

## Requirements
- R1: After reset `busy`, `done`, `fail` and `err` are 0 and every thread ID is free, so the first allocation of any legal size returns start 0.
- R2: Candidate starts are 0, s, 2s, … (s = requested size) for as long as the start is below T. The result is the first candidate whose IDs [start, start+s) are all free, reported with `fail`=0 and `start_idx`=start.
- R3: A candidate whose window runs past ID T-1 counts as not free. When no candidate qualifies, the result is `fail`=1.
- R4: With `alloc_occupy`=0 the occupancy and slot table are left unchanged, so repeating the same probe gives the same answer.
- R5: With `alloc_occupy`=1 a successful search marks every ID of the chosen window occupied and records its start against `alloc_slot`.
- R6: An occupying allocation to a slot that already holds a run ends with `done`=1, `fail`=1 and `err`=1, one edge after the request, and changes nothing.
- R7: A release of a held slot frees [stored start, stored start+`rel_size`) and clears the slot, with `err`=0 in the following cycle. The freed IDs can be allocated again.
- R8: A release of a slot that holds nothing raises `err` for the cycle after the request and changes nothing.
- R9: A size of 0 or a size above T gives `done` with `fail`=1 and `err`=0 one edge after the request, without scanning.
- R10: `done` is high for exactly one cycle. For a search, it rises k+1 edges after the request edge, where k is the number of candidates tested. `busy` is high while candidates are being tested.
- R11: Requests are taken only while `busy` and `done` are both 0. Any release presented while busy or done is dropped. When an allocation and a release arrive together, the allocation is taken and the release is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation or probe request |
| alloc_size | input | $clog2(T+1) | Padded run length requested |
| alloc_occupy | input | 1 | 1 = mark the found run and record the slot, 0 = probe only |
| alloc_slot | input | $clog2(SLOTS) | Block-context slot for an occupying allocation |
| rel_valid | input | 1 | Release request |
| rel_slot | input | $clog2(SLOTS) | Slot whose run is freed |
| rel_size | input | $clog2(T+1) | Length of the run being freed |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| fail | output | 1 | With `done`: no run granted |
| start_idx | output | $clog2(T+1) | With `done` and `fail`=0: first thread ID of the run |
| err | output | 1 | Slot misuse (R6 together with `done`, R8 alone) |

## Verification
A rejected allocation shows its result one edge after the request edge. A search shows its result after one edge more than the number of candidates it tests. The reference model counts the candidates it tests itself and checks that exact edge count on every allocation. Release errors appear in the cycle after the release edge. All outputs are sampled on the falling clock edge, so every check reads values that settled at the preceding rising edge. Probes placed between allocations and releases expose the occupancy, which is not brought out as a port.

// File: rtl/thr_alloc_pkg.sv
package thr_alloc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } alloc_state_e;
endpackage

// File: rtl/thr_window_mask.sv
// Builds a mask of the IDs in [lo, lo+len) over T thread positions.
module thr_window_mask #(
    parameter int T  = 64,
    parameter int CW = 8
) (
    input  logic [CW-1:0] lo,
    input  logic [CW-1:0] len,
    output logic [T-1:0]  mask
);
    logic [CW:0] hi;
    assign hi = {1'b0, lo} + {1'b0, len};

    always_comb begin
        for (int i = 0; i < T; i++) begin
            mask[i] = ((CW+1)'(i) >= {1'b0, lo}) && ((CW+1)'(i) < hi);
        end
    end
endmodule

// File: rtl/thr_slot_table.sv
// Per-slot record of the start ID of the run owned by that slot.
module thr_slot_table #(
    parameter int SLOTS = 8,
    parameter int SW    = 7,
    parameter int LW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [LW-1:0] set_slot,
    input  logic [SW-1:0] set_start,
    input  logic          clr_en,
    input  logic [LW-1:0] clr_slot,
    input  logic [LW-1:0] rd_slot_a,
    output logic          rd_valid_a,
    input  logic [LW-1:0] rd_slot_b,
    output logic          rd_valid_b,
    output logic [SW-1:0] rd_start_b
);
    logic [SLOTS-1:0] held_q;
    logic [SW-1:0]    start_q [SLOTS];

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    held_q[g]  <= 1'b0;
                    start_q[g] <= '0;
                end else if (set_en && set_slot == LW'(g)) begin
                    held_q[g]  <= 1'b1;
                    start_q[g] <= set_start;
                end else if (clr_en && clr_slot == LW'(g)) begin
                    held_q[g]  <= 1'b0;
                end
            end
        end
    endgenerate

    assign rd_valid_a = held_q[rd_slot_a];
    assign rd_valid_b = held_q[rd_slot_b];
    assign rd_start_b = start_q[rd_slot_b];
endmodule

// File: rtl/thr_range_alloc.sv
module thr_range_alloc
    import thr_alloc_pkg::*;
#(
    parameter  int T     = 64,
    parameter  int SLOTS = 8,
    localparam int SW    = $clog2(T + 1),
    localparam int LW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic [SW-1:0] alloc_size,
    input  logic          alloc_occupy,
    input  logic [LW-1:0] alloc_slot,
    input  logic          rel_valid,
    input  logic [LW-1:0] rel_slot,
    input  logic [SW-1:0] rel_size,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [SW-1:0] start_idx,
    output logic          err
);
    localparam int CW = SW + 1;

    alloc_state_e state, state_nx;

    logic [T-1:0]  occ_map;
    logic [SW-1:0] size_q;
    logic          occupy_q;
    logic [LW-1:0] slot_q;
    logic [CW-1:0] cand;
    logic          fail_q, err_q;
    logic [SW-1:0] start_q;

    logic [T-1:0]  scan_mask, rel_mask;
    logic [CW-1:0] cand_nx;
    logic          win_fits, win_free, cand_last;
    logic          slot_held, rel_held;
    logic [SW-1:0] rel_start;
    logic          bad_size, conflict, rel_take;
    logic          tbl_set, tbl_clr;

    thr_window_mask #(.T(T), .CW(CW)) u_scan_win (
        .lo(cand), .len({1'b0, size_q}), .mask(scan_mask)
    );

    thr_window_mask #(.T(T), .CW(CW)) u_rel_win (
        .lo({1'b0, rel_start}), .len({1'b0, rel_size}), .mask(rel_mask)
    );

    thr_slot_table #(.SLOTS(SLOTS), .SW(SW), .LW(LW)) u_table (
        .clk(clk), .rst_n(rst_n),
        .set_en(tbl_set), .set_slot(slot_q), .set_start(cand[SW-1:0]),
        .clr_en(tbl_clr), .clr_slot(rel_slot),
        .rd_slot_a(alloc_slot), .rd_valid_a(slot_held),
        .rd_slot_b(rel_slot), .rd_valid_b(rel_held), .rd_start_b(rel_start)
    );

    assign cand_nx   = cand + CW'(size_q);
    assign win_fits  = (cand_nx <= CW'(T));
    assign win_free  = win_fits && ((occ_map & scan_mask) == '0);
    assign cand_last = (cand_nx >= CW'(T));
    assign bad_size  = (alloc_size == '0) || (alloc_size > SW'(T));
    assign conflict  = alloc_occupy && slot_held;
    assign rel_take  = (state == ST_IDLE) && !alloc_valid && rel_valid;
    assign tbl_set   = (state == ST_SCAN) && win_free && occupy_q;
    assign tbl_clr   = rel_take && rel_held;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (alloc_valid) state_nx = (bad_size || conflict) ? ST_DONE : ST_SCAN;
            ST_SCAN: if (win_free || cand_last) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Datapath: request capture, occupancy updates, result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_map  <= '0;
            size_q   <= '0;
            occupy_q <= 1'b0;
            slot_q   <= '0;
            cand     <= '0;
            fail_q   <= 1'b0;
            err_q    <= 1'b0;
            start_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (alloc_valid) begin
                        size_q   <= alloc_size;
                        occupy_q <= alloc_occupy;
                        slot_q   <= alloc_slot;
                        cand     <= '0;
                        start_q  <= '0;
                        fail_q   <= bad_size || conflict;
                        err_q    <= !bad_size && conflict;
                    end else if (rel_valid) begin
                        err_q <= !rel_held;
                        if (rel_held) occ_map <= occ_map & ~rel_mask;
                    end else begin
                        err_q <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (win_free) begin
                        start_q <= cand[SW-1:0];
                        fail_q  <= 1'b0;
                        if (occupy_q) occ_map <= occ_map | scan_mask;
                    end else if (cand_last) begin
                        start_q <= '0;
                        fail_q  <= 1'b1;
                    end else begin
                        cand <= cand_nx;
                    end
                end
                ST_DONE: err_q <= 1'b0;
                default: err_q <= 1'b0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (state == ST_SCAN);
        done      = (state == ST_DONE);
        fail      = fail_q;
        start_idx = start_q;
        err       = err_q;
    end
endmodule

// File: rtl/thr_range_alloc_chk.sv
module thr_range_alloc_chk #(
    parameter int T  = 64,
    parameter int SW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_valid,
    input logic          rel_valid,
    input logic          busy,
    input logic          done,
    input logic          fail,
    input logic          err,
    input logic [SW-1:0] start_idx,
    input logic [SW-1:0] size_q,
    input logic          occupy_q,
    input logic [T-1:0]  occ_map
);
    localparam int IW = $clog2(T);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(alloc_valid)); // R10
    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> ((32'(start_idx) % 32'(size_q)) == 0)); // R2
    AST_WINDOW_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (32'(start_idx) + 32'(size_q) <= T)); // R3
    AST_PROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !occupy_q) |=> $stable(occ_map)); // R4
    AST_OCC_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail && occupy_q) |-> occ_map[start_idx[IW-1:0]]); // R5
    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !done) |-> $past(rel_valid)); // R8
endmodule

bind thr_range_alloc thr_range_alloc_chk #(.T(T), .SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .rel_valid(rel_valid),
    .busy(busy), .done(done), .fail(fail), .err(err), .start_idx(start_idx),
    .size_q(size_q), .occupy_q(occupy_q), .occ_map(occ_map)
);

// File: tb/thr_range_alloc_bench.sv
module thr_range_alloc_bench;
    localparam int T = 64, SLOTS = 8;
    localparam int SW = $clog2(T + 1), LW = $clog2(SLOTS);

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 0, alloc_occupy = 0, rel_valid = 0;
    logic [SW-1:0] alloc_size = '0, rel_size = '0;
    logic [LW-1:0] alloc_slot = '0, rel_slot = '0;
    logic busy, done, fail, err;
    logic [SW-1:0] start_idx;

    int checks = 0, errors = 0, cycles = 0;
    bit m_occ [T];
    bit m_held [SLOTS];
    int m_start [SLOTS];
    int m_size [SLOTS];

    always #2 clk = ~clk;

    thr_range_alloc #(.T(T), .SLOTS(SLOTS)) u_thr_range_alloc (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_size(alloc_size),
        .alloc_occupy(alloc_occupy), .alloc_slot(alloc_slot), .rel_valid(rel_valid),
        .rel_slot(rel_slot), .rel_size(rel_size), .busy(busy), .done(done),
        .fail(fail), .start_idx(start_idx), .err(err)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit run_free(int s, int n);
        if (s + n > T) return 0;
        for (int i = s; i < s + n; i++) if (m_occ[i]) return 0;
        return 1;
    endfunction

    // Allocation/probe; rel_same: release presented in the same cycle,
    // rel_mid: release pulsed during the search (both must be dropped, R11)
    task automatic do_alloc(int size, bit occ, int slot, string req,
                            bit rel_same = 0, bit rel_mid = 0, int rslot = 0);
        bit e_fail, e_err, found;
        int e_start, e_lat, tested, lat;
        e_err = 0; e_start = 0; found = 0; tested = 0;
        if (size == 0 || size > T) begin
            e_fail = 1; e_lat = 1;                        // R9
        end else if (occ && m_held[slot]) begin
            e_fail = 1; e_err = 1; e_lat = 1;             // R6
        end else begin
            for (int s = 0; s < T; s += size) begin       // R2, R3
                tested++;
                if (run_free(s, size)) begin found = 1; e_start = s; break; end
            end
            e_fail = !found; e_lat = tested + 1;          // R10
            if (found && occ) begin                        // R5
                for (int i = e_start; i < e_start + size; i++) m_occ[i] = 1;
                m_held[slot] = 1; m_start[slot] = e_start; m_size[slot] = size;
            end
        end
        @(negedge clk);
        alloc_valid = 1; alloc_size = SW'(size); alloc_occupy = occ; alloc_slot = LW'(slot);
        rel_valid = rel_same; rel_slot = LW'(rslot); rel_size = SW'(m_size[rslot]);
        @(posedge clk);
        @(negedge clk);
        alloc_valid = 0; rel_valid = 0;
        lat = 1;
        while (!done && lat < 200) begin
            if (rel_mid && lat == 1) begin
                check(busy == 1, "R10", "busy during search", busy, 1);
                rel_valid = 1; rel_slot = LW'(rslot); rel_size = SW'(m_size[rslot]);
            end
            @(posedge clk);
            @(negedge clk);
            rel_valid = 0;
            lat++;
        end
        check(lat == e_lat, "R10", "edges to done", lat, e_lat);
        check(fail == e_fail, req, "fail", fail, e_fail);
        if (!e_fail) check(int'(start_idx) == e_start, req, "start_idx", start_idx, e_start);
        check(err == e_err, (e_err ? "R6" : req), "err", err, e_err);
        @(negedge clk);
        check(done == 0, "R10", "done one cycle", done, 0);
    endtask

    task automatic do_release(int slot, int size, string req);
        bit e_err;
        e_err = !m_held[slot];                            // R8
        if (m_held[slot]) begin                           // R7
            for (int i = m_start[slot]; i < m_start[slot] + size && i < T; i++) m_occ[i] = 0;
            m_held[slot] = 0;
        end
        @(negedge clk);
        rel_valid = 1; rel_slot = LW'(slot); rel_size = SW'(size);
        @(posedge clk);
        @(negedge clk);
        rel_valid = 0;
        check(err == e_err, req, "release err", err, e_err);
        check(done == 0 && busy == 0, req, "release stays idle", done, 0);
    endtask

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        for (int i = 0; i < SLOTS; i++) begin m_held[i] = 0; m_start[i] = 0; m_size[i] = 0; end
        for (int i = 0; i < T; i++) m_occ[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 0 && done == 0 && fail == 0 && err == 0, "R1", "reset outputs",
              {busy, done, fail, err}, 0);
        rst_n = 1;
        do_alloc(16, 1, 0, "R1");         // start 0, 2 edges
        do_alloc(16, 1, 1, "R2");         // start 16 after 0 busy
        do_alloc(32, 0, 2, "R4");         // probe: 32
        do_alloc(32, 0, 2, "R4");         // same probe, same answer
        do_alloc(8, 1, 0, "R6");          // slot 0 held
        do_alloc(0, 1, 3, "R9");
        do_alloc(T + 1, 1, 3, "R9");
        do_alloc(T, 0, 3, "R3");          // only candidate busy
        do_alloc(24, 0, 3, "R3");         // 0,24 busy; 48 runs past T
        do_release(1, 16, "R7");
        do_alloc(16, 0, 3, "R7");         // freed run is found again: 16
        do_release(5, 8, "R8");
        do_alloc(8, 0, 3, "R8");          // unchanged after bad release
        do_alloc(8, 1, 2, "R11", 0, 1, 0); // release of slot 0 mid-search dropped
        do_alloc(4, 0, 3, "R11", 1, 0, 2); // release of slot 2 with alloc dropped
        do_release(0, 16, "R11");          // slot 0 still held: err 0
        do_release(2, 8, "R11");           // slot 2 still held: err 0
        for (int n = 0; n < 400; n++) begin
            int op, sl, sz;
            op = $urandom_range(0, 9);
            sl = $urandom_range(0, SLOTS - 1);
            case ($urandom_range(0, 3))
                0: sz = 1 << $urandom_range(0, 6);
                1: sz = $urandom_range(1, 12);
                2: sz = $urandom_range(1, T);
                default: sz = $urandom_range(0, T + 2);
            endcase
            if (op < 5)      do_alloc(sz, 1, sl, "R5");
            else if (op < 7) do_alloc(sz, 0, sl, "R2");
            else             do_release(sl, m_held[sl] ? m_size[sl] : sz, "R7");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule